// File: doc/BRIEF.md
# Programmable Counter/Timer with Clock Select

This block is the shared counter/timer of a two-channel serial controller. A 16-bit down-counter is preset from two byte-wide values and is advanced by a tick taken from one of several clock sources. The sources are an external input pin, the 1x transmit clocks of channel A and channel B, and a crystal reference enable. Each of the external pin and the crystal reference can also be divided by 16. A 3-bit mode field selects both the operating mode and the tick source at once.

In counter mode the block performs a one-shot count. A start strobe loads the preset, and the count runs down to terminal count, where it raises a ready flag and halts. In timer mode the count runs freely. Each arrival at zero reloads the preset and toggles a square-wave output. The ready flag rises once per full square-wave period. A stop strobe clears the ready flag in both modes. In counter mode it also halts the count, while in timer mode it leaves the timer running.

The whole block runs on one system clock. The asynchronous pin and transmit clocks pass through a two-flop synchroniser with a rising-edge detector. The divide-by-16 sources come from 4-bit prescalers that emit a one-cycle enable.

Top module: `ctr_timer`

## Requirements
- R1: While `rst_n` is low and on release, `count_val`, `ready` and `wave_out` are 0, and `active` is 0 when `mode_sel[2]` is 0.
- R2: `mode_sel[2]`=0 selects counter mode and 1 selects timer mode. The tick source is: 000 external pin, 001 channel A transmit clock, 010 channel B transmit clock, 011 crystal/16, 100 external pin, 101 external pin/16, 110 crystal, 111 crystal/16.
- R3: A rising edge on `ext_pin`, `txa_clk` or `txb_clk` produces exactly one tick. Suppose the pin is high before clock edge k and was low before edge k-1. The counter then acts at edge k+2.
- R4: A divided source gives one tick per 16 source pulses. Each of the two prescalers counts its own source in every mode.
- R5: A `start_cmd` strobe loads `{preset_hi, preset_lo}` into the count and clears `wave_out`. In counter mode it also sets `active`. While active, each tick decrements the count.
- R6: In counter mode, a tick while active with a count of 0 or 1 sets the count to 0, sets `ready` and clears `active`. While `active` is 0, ticks leave the count unchanged.
- R7: In counter mode `stop_cmd` clears `ready` and `active` and holds the count. If `start_cmd` arrives in the same cycle, the start still loads and activates.
- R8: In timer mode, a tick with a count of 0 or 1 reloads the preset and toggles `wave_out`. Other ticks decrement the count, so each half-period lasts preset ticks.
- R9: In timer mode, `ready` is set only by the zero arrival that takes `wave_out` from 1 to 0, which is every second zero.
- R10: In timer mode `stop_cmd` clears `ready` but leaves the count and `wave_out` running. `active` is 1 whenever `mode_sel[2]` is 1.
- R11: When a ready-setting event and `stop_cmd` fall in the same cycle, `ready` ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 3 | Mode and tick-source select |
| preset_hi | input | 8 | Upper byte of the preset |
| preset_lo | input | 8 | Lower byte of the preset |
| start_cmd | input | 1 | Start strobe, one cycle |
| stop_cmd | input | 1 | Stop strobe, one cycle |
| ext_pin | input | 1 | Asynchronous external clock pin |
| txa_clk | input | 1 | Channel A transmit 1x clock, asynchronous |
| txb_clk | input | 1 | Channel B transmit 1x clock, asynchronous |
| xtal_en | input | 1 | Crystal reference enable pulse, synchronous |
| count_val | output | 16 | Current count |
| ready | output | 1 | Counter/timer ready flag |
| wave_out | output | 1 | Square-wave output |
| active | output | 1 | Counting in progress |

## Verification
The assertions take for granted that `xtal_en` is already synchronous to `clk`. They also assume that the three asynchronous pins are sampled only through the synchroniser, so no assertion depends on when a pin changes within a cycle. A further assumption is that `mode_sel` may change at any cycle without breaking the relation between a zero arrival and the ready and wave flags. The stimulus changes all inputs one time unit after the falling clock edge. It toggles the pins at random and raises `xtal_en` at random. Random segments each hold one mode value with a random preset. Directed runs cover the synchroniser latency, the divide-by-16 spacing, the every-second-zero ready rule and a stop strobe that collides with a ready event.

// File: rtl/ctr_timer_pkg.sv
package ctr_timer_pkg;
  localparam int DEF_BYTE_W = 8;
  localparam int DEF_DIV_W  = 4;

  typedef enum logic [2:0] {
    SRC_EXT, SRC_EXT16, SRC_TXA, SRC_TXB, SRC_XTAL, SRC_XTAL16
  } src_t;

  // Mode bit 2 picks the square-wave timer (R2)
  function automatic logic is_timer(input logic [2:0] mode);
    return mode[2];
  endfunction

  // Tick source for each of the eight mode codes (R2)
  function automatic src_t decode_src(input logic [2:0] mode);
    case (mode)
      3'b000:  return SRC_EXT;
      3'b001:  return SRC_TXA;
      3'b010:  return SRC_TXB;
      3'b011:  return SRC_XTAL16;
      3'b100:  return SRC_EXT;
      3'b101:  return SRC_EXT16;
      3'b110:  return SRC_XTAL;
      default: return SRC_XTAL16;
    endcase
  endfunction
endpackage

// File: rtl/ctr_edge_sync.sv
module ctr_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic pulse
);
  logic [STAGES-1:0] chain;
  logic              last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain <= '0;
      last  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], din};
      last  <= chain[STAGES-1];
    end
  end

  assign pulse = chain[STAGES-1] & ~last;

  AST_EDGE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse); // R3
endmodule

// File: rtl/ctr_prescale.sv
module ctr_prescale #(
  parameter int DIV_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic src_tick,
  output logic div_tick
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt <= '0;
    else if (src_tick) cnt <= cnt + 1'b1;
  end

  assign div_tick = src_tick && (cnt == {DIV_W{1'b1}});

  AST_DIV_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
    div_tick |=> (cnt == '0)); // R4
endmodule

// File: rtl/ctr_clk_select.sv
module ctr_clk_select
  import ctr_timer_pkg::*;
#(
  parameter int DIV_W = DEF_DIV_W
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] mode,
  input  logic       ext_tick,
  input  logic       txa_tick,
  input  logic       txb_tick,
  input  logic       xtal_tick,
  output logic       tick
);
  logic ext_div, xtal_div;
  src_t src;

  ctr_prescale #(.DIV_W(DIV_W)) u_ext_div (
    .clk(clk), .rst_n(rst_n), .src_tick(ext_tick), .div_tick(ext_div));
  ctr_prescale #(.DIV_W(DIV_W)) u_xtal_div (
    .clk(clk), .rst_n(rst_n), .src_tick(xtal_tick), .div_tick(xtal_div));

  assign src = decode_src(mode);

  always_comb begin
    case (src)
      SRC_EXT:    tick = ext_tick;
      SRC_EXT16:  tick = ext_div;
      SRC_TXA:    tick = txa_tick;
      SRC_TXB:    tick = txb_tick;
      SRC_XTAL:   tick = xtal_tick;
      SRC_XTAL16: tick = xtal_div;
      default:    tick = 1'b0;
    endcase
  end

  AST_DIV_SOURCE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && src == SRC_XTAL16) |-> xtal_tick); // R4
endmodule

// File: rtl/ctr_core.sv
module ctr_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             timer_mode,
  input  logic             tick,
  input  logic             start,
  input  logic             stop,
  input  logic [CNT_W-1:0] preset,
  output logic [CNT_W-1:0] count,
  output logic             ready,
  output logic             wave,
  output logic             running
);
  logic zero_hit;
  logic set_ready;
  logic counting;

  assign counting  = timer_mode || running;
  assign zero_hit  = tick && counting && !start && (count <= CNT_W'(1));
  assign set_ready = zero_hit && (!timer_mode || wave);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count   <= '0;
      wave    <= 1'b0;
      running <= 1'b0;
    end else begin
      if (start) begin
        count   <= preset;
        wave    <= 1'b0;
        running <= !timer_mode;
      end else if (zero_hit) begin
        if (timer_mode) begin
          count <= preset;
          wave  <= ~wave;
        end else begin
          count   <= '0;
          running <= 1'b0;
        end
      end else begin
        if (tick && counting) count <= count - 1'b1;
        if (stop && !timer_mode) running <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         ready <= 1'b0;
    else if (set_ready) ready <= 1'b1;
    else if (stop)      ready <= 1'b0;
  end

  AST_READY_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(zero_hit)); // R6
  AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !zero_hit) |=> !ready); // R7
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!timer_mode && !running && !start) |=> $stable(count)); // R6
  AST_WAVE_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
    (timer_mode && zero_hit) |=> (wave != $past(wave))); // R8
  AST_TIMER_KEEPS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (timer_mode && stop && !start && tick && !zero_hit) |=> (count == $past(count) - 1'b1)); // R10
endmodule

// File: rtl/ctr_timer.sv
module ctr_timer
  import ctr_timer_pkg::*;
#(
  parameter int BYTE_W = DEF_BYTE_W,
  parameter int DIV_W  = DEF_DIV_W,
  parameter int SYNC_N = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2:0]          mode_sel,
  input  logic [BYTE_W-1:0]   preset_hi,
  input  logic [BYTE_W-1:0]   preset_lo,
  input  logic                start_cmd,
  input  logic                stop_cmd,
  input  logic                ext_pin,
  input  logic                txa_clk,
  input  logic                txb_clk,
  input  logic                xtal_en,
  output logic [2*BYTE_W-1:0] count_val,
  output logic                ready,
  output logic                wave_out,
  output logic                active
);
  localparam int CNT_W = 2 * BYTE_W;

  logic [2:0] pin_vec;
  logic [2:0] pin_tick;
  logic       tick;
  logic       running;
  logic       timer_mode;

  assign pin_vec    = {txb_clk, txa_clk, ext_pin};
  assign timer_mode = is_timer(mode_sel);

  for (genvar i = 0; i < 3; i++) begin : g_sync
    ctr_edge_sync #(.STAGES(SYNC_N)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(pin_vec[i]), .pulse(pin_tick[i]));
  end

  ctr_clk_select #(.DIV_W(DIV_W)) u_sel (
    .clk(clk), .rst_n(rst_n), .mode(mode_sel),
    .ext_tick(pin_tick[0]), .txa_tick(pin_tick[1]), .txb_tick(pin_tick[2]),
    .xtal_tick(xtal_en), .tick(tick));

  ctr_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .timer_mode(timer_mode), .tick(tick),
    .start(start_cmd), .stop(stop_cmd), .preset({preset_hi, preset_lo}),
    .count(count_val), .ready(ready), .wave(wave_out), .running(running));

  assign active = timer_mode || running;

  AST_TIMER_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    mode_sel[2] |-> active); // R10
endmodule

// File: tb/ctr_timer_test.sv
module ctr_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  mode_sel = 3'b000;
  logic [7:0]  preset_hi = 8'h00, preset_lo = 8'h00;
  logic        start_cmd = 1'b0, stop_cmd = 1'b0;
  logic        ext_pin = 1'b0, txa_clk = 1'b0, txb_clk = 1'b0, xtal_en = 1'b0;
  logic [15:0] count_val;
  logic        ready, wave_out, active;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  bit model_on = 1'b0;

  always #2 clk = ~clk;

  ctr_timer uut (.*);

  // ---------------- bench-side expectation model ----------------
  logic [2:0]  e_s, a_s, b_s;
  logic [3:0]  m_ep, m_xp;
  logic [15:0] m_cnt;
  logic        m_ready, m_wave, m_run;

  // Source choice per mode code, R2
  function automatic logic f_pick(input logic [2:0] m, input logic e, a, b, x, ed, xd);
    case (m)
      3'd0, 3'd4: return e;
      3'd1:       return a;
      3'd2:       return b;
      3'd5:       return ed;
      3'd6:       return x;
      default:    return xd;
    endcase
  endfunction

  // Zero arrival: count of 0 or 1 means this tick ends the run (R6, R8)
  function automatic logic f_last_tick(input logic [15:0] c);
    return (c == 16'd0) || (c == 16'd1);
  endfunction

  always @(posedge clk) begin
    logic pe, pa, pb, ed, xd, tk, tm, hit, setr;
    if (!rst_n) begin
      e_s = '0; a_s = '0; b_s = '0; m_ep = '0; m_xp = '0;
      m_cnt = '0; m_ready = 0; m_wave = 0; m_run = 0;
    end else begin
      pe = e_s[1] & ~e_s[2];
      pa = a_s[1] & ~a_s[2];
      pb = b_s[1] & ~b_s[2];
      e_s = {e_s[1], e_s[0], ext_pin};
      a_s = {a_s[1], a_s[0], txa_clk};
      b_s = {b_s[1], b_s[0], txb_clk};
      ed = pe && (m_ep == 4'd15);
      xd = xtal_en && (m_xp == 4'd15);
      if (pe) m_ep = m_ep + 4'd1;
      if (xtal_en) m_xp = m_xp + 4'd1;
      tk = f_pick(mode_sel, pe, pa, pb, xtal_en, ed, xd);
      tm = mode_sel[2];
      hit = tk && (tm || m_run) && !start_cmd && f_last_tick(m_cnt);
      setr = hit && (!tm || m_wave);
      if (setr) m_ready = 1'b1;
      else if (stop_cmd) m_ready = 1'b0;
      if (start_cmd) begin
        m_cnt = {preset_hi, preset_lo}; m_wave = 1'b0; m_run = !tm;
      end else if (hit) begin
        if (tm) begin m_cnt = {preset_hi, preset_lo}; m_wave = ~m_wave; end
        else begin m_cnt = 16'd0; m_run = 1'b0; end
      end else begin
        if (tk && (tm || m_run)) m_cnt = m_cnt - 16'd1;
        if (stop_cmd && !tm) m_run = 1'b0;
      end
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (model_on && rst_n) begin
      chk(m_run ? "R5 count" : "R6/R8 count", count_val, m_cnt);
      chk(mode_sel[2] ? "R9 ready" : "R6 ready", {15'd0, ready}, {15'd0, m_ready});
      chk("R8 wave", {15'd0, wave_out}, {15'd0, m_wave});
      chk("R10 active", {15'd0, active}, {15'd0, mode_sel[2] | m_run});
    end
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic pulse_start();
    start_cmd = 1'b1; step(); start_cmd = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
    end
  end

  initial begin : main
    int r, n;
    bit seen;
    r = $urandom(32'd20240);
    // R1: reset state
    repeat (3) step();
    chk("R1 count", count_val, 16'd0);
    chk("R1 ready", {15'd0, ready}, 16'd0);
    chk("R1 wave", {15'd0, wave_out}, 16'd0);
    chk("R1 active", {15'd0, active}, 16'd0);
    rst_n = 1'b1;
    step();
    chk("R1 after release", count_val, 16'd0);
    model_on = 1'b1;

    // R3: pin edge reaches the counter at the third edge
    mode_sel = 3'b000; preset_lo = 8'd5; pulse_start();
    chk("R5 load", count_val, 16'd5);
    ext_pin = 1'b1; step(); step();
    chk("R3 not yet", count_val, 16'd5);
    step();
    chk("R3 one tick", count_val, 16'd4);
    repeat (4) step();
    chk("R3 single tick per edge", count_val, 16'd4);
    ext_pin = 1'b0; repeat (3) step();

    // R4: crystal/16 gives a tick every 16 cycles in timer mode
    mode_sel = 3'b111; preset_lo = 8'd1; xtal_en = 1'b1; pulse_start();
    begin
      logic w0;
      w0 = wave_out; n = 0;
      while (wave_out == w0 && n < 100) begin step(); n++; end
      w0 = wave_out; n = 0;
      while (wave_out == w0 && n < 100) begin step(); n++; end
      chk("R4 divided spacing", 16'(n), 16'd16);
    end

    // R8/R9: half period = preset ticks, ready on the falling wave only
    mode_sel = 3'b110; preset_lo = 8'd3; pulse_start();
    n = 0; while (!wave_out && n < 50) begin step(); n++; end
    n = 0; while (wave_out && n < 50) begin step(); n++; end
    chk("R8 half period", 16'(n), 16'd3);
    chk("R9 ready on falling zero", {15'd0, ready}, 16'd1);
    stop_cmd = 1'b1; step(); stop_cmd = 1'b0;
    chk("R10 stop clears ready", {15'd0, ready}, 16'd0);
    n = 0; while (!wave_out && n < 50) begin step(); n++; end
    chk("R9 no ready on rising zero", {15'd0, ready}, 16'd0);
    chk("R10 timer still runs", {15'd0, active}, 16'd1);

    // R11: stop held during ready events, preset 1 -> zero every tick
    preset_lo = 8'd1; pulse_start();
    stop_cmd = 1'b1; seen = 1'b0;
    for (int i = 0; i < 20; i++) begin step(); if (ready) seen = 1'b1; end
    stop_cmd = 1'b0;
    chk("R11 set beats stop", {15'd0, seen}, 16'd1);

    // R7: counter stop halts and holds
    mode_sel = 3'b110; xtal_en = 1'b0; step();
    mode_sel = 3'b011; preset_lo = 8'd40; preset_hi = 8'd0; pulse_start();
    xtal_en = 1'b1; repeat (40) step();
    stop_cmd = 1'b1; step(); stop_cmd = 1'b0;
    n = int'(count_val);
    repeat (40) step();
    chk("R7 count held after stop", count_val, 16'(n));
    chk("R7 inactive after stop", {15'd0, active}, 16'd0);

    // Random segments over all modes (R2, R4, R5, R6, R8)
    for (int s = 0; s < 48; s++) begin
      mode_sel = 3'($urandom_range(0, 7));
      preset_hi = ($urandom_range(0, 9) == 0) ? 8'($urandom_range(0, 1)) : 8'd0;
      preset_lo = 8'($urandom_range(0, 12));
      pulse_start();
      for (int c = 0; c < 500; c++) begin
        xtal_en   = ($urandom_range(0, 1) == 0);
        if ($urandom_range(0, 2) == 0) ext_pin = ~ext_pin;
        if ($urandom_range(0, 2) == 0) txa_clk = ~txa_clk;
        if ($urandom_range(0, 2) == 0) txb_clk = ~txb_clk;
        stop_cmd  = ($urandom_range(0, 60) == 0);
        start_cmd = ($urandom_range(0, 150) == 0);
        step();
      end
      start_cmd = 1'b0; stop_cmd = 1'b0;
    end
    finish_run();
  end
endmodule